// File: doc/BRIEF.md
# One-Time-Programmable Array Burn-and-Check Sequencer

This block drives a one-time-programmable byte array through a full programming run. After a start strobe it walks the array from address zero. It fetches each target byte from an image source and reads the cell first. It then applies fixed-length write pulses, and after every pulse it reads the cell back with the programming supply still high. A byte moves on once the read-back matches. A byte that still disagrees after the allowed number of pulses ends the run as a failure.

When the last byte has passed, the sequencer drops the programming supply back to the normal level and reads every byte once more against the image. A mismatch in this pass fails the run. A run may also ask for the array to be locked against readout. In that case, after a clean compare, one extra write pulse goes to the fixed lock location in register space. The mode pins follow fixed combinations. Plain read uses the normal supply. Program uses high supply with the read/write control low. Verify uses high supply with the control high. Lock uses high supply, register select high and the control low.

Top module: `otp_burn_seq`

## Requirements
- R1: After reset, busy, pass, fail, cell_hv, cell_regsel and cell_wpulse are 0 and cell_rw is 1 (plain read mode).
- R2: The mode pins take only these values: read (hv=0, rw=1, regsel=0), program (hv=1, rw=0, regsel=0), verify (hv=1, rw=1, regsel=0) and lock (hv=1, rw=0, regsel=1). The write pulse is high only in program or lock mode, so with hv=0 no pulse is issued.
- R3: Every write pulse stays high for exactly PULSE_CYC = CLK_KHZ*PULSE_US/1000 consecutive cycles.
- R4: Programming starts at address 0 and advances by exactly one after each byte passes verify, up to DEPTH-1.
- R5: A byte receives at most MAX_TRY pulses. If the verify after the MAX_TRY-th pulse still mismatches, the run ends with fail.
- R6: The pulse count is cleared when the address advances, so each byte that passes receives exactly as many pulses as it needs.
- R7: Before the first pulse of a byte, the cell is read. If the target has a 1 where the cell holds 0, the run fails at once and that byte gets no pulse.
- R8: After the last byte, every address 0..DEPTH-1 is read again with hv=0 and rw=1. Any mismatch ends the run with fail.
- R9: If prot_req is high at start and the final compare is clean, one lock pulse is issued (lock mode, cell_addr = PROT_ADDR) before pass rises. If the compare fails, no lock pulse is issued.
- R10: busy rises the cycle after an accepted start and falls in the cycle that pass or fail rises. pass and fail are never both high, and they hold until the next start. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| prot_req | input | 1 | Lock the array after a clean run (sampled at start) |
| img_addr | output | ADDR_W | Address of the image byte wanted |
| img_data | input | DATA_W | Image byte at img_addr, combinational |
| cell_addr | output | ADDR_W | Array address (PROT_ADDR in lock mode) |
| cell_wdata | output | DATA_W | Byte to program |
| cell_wpulse | output | 1 | Write pulse |
| cell_rdata | input | DATA_W | Array read data for cell_addr, combinational |
| cell_hv | output | 1 | Programming supply at high level |
| cell_rw | output | 1 | 1 = read/verify, 0 = program |
| cell_regsel | output | 1 | Register-space select (lock only) |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Run completed successfully (latched) |
| fail | output | 1 | Run failed (latched) |

## Verification
The assertions assume that cell_rdata and img_data are settled within the cycle their address is presented. They also assume the array model only clears bits when pulsed. The bench model meets this. It reads its array combinationally from cell_addr, and a pulse only ANDs the target into the cell after a per-address number of pulses. The sweeps vary, per address, the pulses needed, preloaded zero bits, and cells that read differently once the supply drops. In every case the expected pulse counts, addresses and outcome are computed arithmetically from those tables.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
   typedef enum logic [1:0] {
      OM_READ   = 2'd0,
      OM_PROG   = 2'd1,
      OM_VERIFY = 2'd2,
      OM_LOCK   = 2'd3
   } otp_mode_e;

   typedef enum logic [2:0] {
      S_IDLE    = 3'd0,
      S_CHECK   = 3'd1,
      S_PULSE   = 3'd2,
      S_VERIFY  = 3'd3,
      S_COMPARE = 3'd4,
      S_LOCK    = 3'd5
   } seq_state_e;
endpackage

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
   parameter int unsigned LIM = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int unsigned CW = $clog2(LIM + 1);

   logic [CW-1:0] cnt;

   initial begin
      if (LIM < 1) $error("pulse length must be at least one cycle");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == CW'(LIM - 1));

   // R3
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (32'(cnt) < LIM));
endmodule

// File: rtl/otp_try_ctr.sv
module otp_try_ctr #(
   parameter int unsigned MAX_TRY = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_cap
);
   localparam int unsigned TW = $clog2(MAX_TRY + 1);

   logic [TW-1:0] cnt;

   initial begin
      if (MAX_TRY < 1) $error("retry limit must be at least one");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   assign at_cap = (cnt == TW'(MAX_TRY));

   // R5
   try_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) <= MAX_TRY);

   // R6
   try_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/otp_mode_drv.sv
module otp_mode_drv
   import otp_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] PROT_ADDR = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  otp_mode_e         mode,
   input  logic [ADDR_W-1:0] arr_addr,
   input  logic              wp_req,
   output logic [ADDR_W-1:0] cell_addr,
   output logic              cell_hv,
   output logic              cell_rw,
   output logic              cell_regsel,
   output logic              cell_wpulse
);
   always_comb begin
      cell_hv     = 1'b0;
      cell_rw     = 1'b1;
      cell_regsel = 1'b0;
      cell_addr   = arr_addr;
      unique case (mode)
         OM_READ:   ;
         OM_PROG:   begin cell_hv = 1'b1; cell_rw = 1'b0; end
         OM_VERIFY: cell_hv = 1'b1;
         OM_LOCK:   begin
            cell_hv     = 1'b1;
            cell_rw     = 1'b0;
            cell_regsel = 1'b1;
            cell_addr   = PROT_ADDR;
         end
         default:   ;
      endcase
   end

   assign cell_wpulse = wp_req && (mode == OM_PROG || mode == OM_LOCK);

   // R2
   wp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cell_wpulse |-> (cell_hv && !cell_rw));

   // R2
   plain_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_hv |-> (cell_rw && !cell_regsel && !cell_wpulse));
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
   import otp_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DEPTH     = 4096,
   parameter int unsigned MAX_TRY   = 10,
   parameter int unsigned CLK_KHZ   = 125000,
   parameter int unsigned PULSE_US  = 1000,
   parameter bit          PROT_EN   = 1'b1,
   parameter logic [ADDR_W-1:0] PROT_ADDR = 12'hE3F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              prot_req,
   output logic [ADDR_W-1:0] img_addr,
   input  logic [DATA_W-1:0] img_data,
   output logic [ADDR_W-1:0] cell_addr,
   output logic [DATA_W-1:0] cell_wdata,
   output logic              cell_wpulse,
   input  logic [DATA_W-1:0] cell_rdata,
   output logic              cell_hv,
   output logic              cell_rw,
   output logic              cell_regsel,
   output logic              busy,
   output logic              pass,
   output logic              fail
);
   localparam int unsigned PULSE_CYC = (CLK_KHZ * PULSE_US) / 1000;
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

   initial begin
      if (DEPTH < 1 || DEPTH > (1 << ADDR_W)) $error("DEPTH does not fit ADDR_W");
      if (PULSE_CYC < 1) $error("pulse shorter than one clock");
      if (DATA_W < 1) $error("DATA_W must be positive");
   end

   seq_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic              lock_q;
   logic              pulse_done;
   logic              at_cap;
   logic              try_clr;
   logic              try_inc;
   logic              prot_in;
   otp_mode_e         mode;

   // lock path present only when the option is built in
   generate
      if (PROT_EN) begin : g_lock
         assign prot_in = prot_req;
      end else begin : g_nolock
         logic unused_prot;
         assign unused_prot = prot_req;
         assign prot_in     = 1'b0;
      end
   endgenerate

   logic bad_bits;
   logic match;
   assign bad_bits = |(img_data & ~cell_rdata);
   assign match    = (img_data == cell_rdata);

   always_comb begin
      unique case (state)
         S_CHECK, S_VERIFY: mode = OM_VERIFY;
         S_PULSE:           mode = OM_PROG;
         S_LOCK:            mode = OM_LOCK;
         default:           mode = OM_READ;
      endcase
   end

   assign try_clr = (state == S_IDLE) ||
                    (state == S_VERIFY && match && addr_q != LAST_A);
   assign try_inc = (state == S_PULSE) && pulse_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         addr_q <= '0;
         lock_q <= 1'b0;
         busy   <= 1'b0;
         pass   <= 1'b0;
         fail   <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE: if (start) begin
               addr_q <= '0;
               lock_q <= prot_in;
               busy   <= 1'b1;
               pass   <= 1'b0;
               fail   <= 1'b0;
               state  <= S_CHECK;
            end
            S_CHECK: begin
               if (bad_bits) begin
                  busy  <= 1'b0;
                  fail  <= 1'b1;
                  state <= S_IDLE;
               end else begin
                  state <= S_PULSE;
               end
            end
            S_PULSE: if (pulse_done) state <= S_VERIFY;
            S_VERIFY: begin
               if (match) begin
                  if (addr_q == LAST_A) begin
                     addr_q <= '0;
                     state  <= S_COMPARE;
                  end else begin
                     addr_q <= addr_q + 1'b1;
                     state  <= S_CHECK;
                  end
               end else if (bad_bits || at_cap) begin
                  busy  <= 1'b0;
                  fail  <= 1'b1;
                  state <= S_IDLE;
               end else begin
                  state <= S_PULSE;
               end
            end
            S_COMPARE: begin
               if (!match) begin
                  busy  <= 1'b0;
                  fail  <= 1'b1;
                  state <= S_IDLE;
               end else if (addr_q == LAST_A) begin
                  if (lock_q) begin
                     state <= S_LOCK;
                  end else begin
                     busy  <= 1'b0;
                     pass  <= 1'b1;
                     state <= S_IDLE;
                  end
               end else begin
                  addr_q <= addr_q + 1'b1;
               end
            end
            S_LOCK: if (pulse_done) begin
               busy  <= 1'b0;
               pass  <= 1'b1;
               state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   otp_pulse_timer #(.LIM(PULSE_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == S_PULSE || state == S_LOCK),
      .done  (pulse_done)
   );

   otp_try_ctr #(.MAX_TRY(MAX_TRY)) u_tries (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (try_clr),
      .inc    (try_inc),
      .at_cap (at_cap)
   );

   otp_mode_drv #(.ADDR_W(ADDR_W), .PROT_ADDR(PROT_ADDR)) u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .arr_addr    (addr_q),
      .wp_req      (state == S_PULSE || state == S_LOCK),
      .cell_addr   (cell_addr),
      .cell_hv     (cell_hv),
      .cell_rw     (cell_rw),
      .cell_regsel (cell_regsel),
      .cell_wpulse (cell_wpulse)
   );

   assign img_addr   = addr_q;
   assign cell_wdata = img_data;

   // R10
   outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass && fail));

   // R10
   busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!pass && !fail));

   // R10
   outcome_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(pass) && $stable(fail)));

   // R3
   pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_PULSE && pulse_done) |=> !cell_wpulse);

   // R4
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_CHECK && $past(state) == S_VERIFY) |-> (addr_q == $past(addr_q) + 1'b1));

   // R8
   compare_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_COMPARE) |-> (!cell_hv && cell_rw));
endmodule

// File: tb/otp_burn_seq_tb.sv
module otp_burn_seq_tb;
   localparam int AW = 12;
   localparam int DW = 8;
   localparam int N  = 8;
   localparam int MT = 3;
   localparam int PC = 4;
   localparam logic [AW-1:0] PA = 12'hE3F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic prot_req = 1'b0;
   logic [AW-1:0] img_addr, cell_addr;
   logic [DW-1:0] img_data, cell_wdata, cell_rdata;
   logic cell_wpulse, cell_hv, cell_rw, cell_regsel, busy, pass, fail;

   always #4 clk = ~clk;

   otp_burn_seq #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(N), .MAX_TRY(MT),
                  .CLK_KHZ(PC), .PULSE_US(1000), .PROT_EN(1'b1), .PROT_ADDR(PA)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .prot_req(prot_req),
      .img_addr(img_addr), .img_data(img_data), .cell_addr(cell_addr),
      .cell_wdata(cell_wdata), .cell_wpulse(cell_wpulse), .cell_rdata(cell_rdata),
      .cell_hv(cell_hv), .cell_rw(cell_rw), .cell_regsel(cell_regsel),
      .busy(busy), .pass(pass), .fail(fail));

   // stimulus tables
   logic [DW-1:0] img_tab [N];
   logic [DW-1:0] pre_tab [N];
   logic [DW-1:0] leak_tab [N];
   int            need [N];

   // array model
   logic [DW-1:0] mem [N];
   int            pcnt [N];
   int            pulses, prot_cnt, wbad, order_bad, wcnt;
   logic [AW-1:0] last_a;
   logic          wp_q;
   logic          clr_req = 1'b0;

   assign img_data = (img_addr < N) ? img_tab[img_addr[2:0]] : 8'h00;
   assign cell_rdata = (cell_addr < N && !cell_regsel)
                       ? (mem[cell_addr[2:0]] ^ (cell_hv ? 8'h00 : leak_tab[cell_addr[2:0]]))
                       : 8'hFF;

   always @(posedge clk) begin
      if (clr_req) begin
         for (int i = 0; i < N; i++) begin mem[i] <= pre_tab[i]; pcnt[i] <= 0; end
         pulses <= 0; prot_cnt <= 0; wbad <= 0; order_bad <= 0; wcnt <= 0;
         last_a <= '0; wp_q <= 1'b0;
      end else begin
         wp_q <= cell_wpulse;
         if (cell_wpulse) wcnt <= wcnt + 1;
         else if (wcnt != 0) begin
            if (wcnt != PC) wbad <= wbad + 1;
            wcnt <= 0;
         end
         if (cell_wpulse && !wp_q) begin
            if (cell_hv && !cell_rw && !cell_regsel && cell_addr < N) begin
               pulses <= pulses + 1;
               pcnt[cell_addr[2:0]] <= pcnt[cell_addr[2:0]] + 1;
               if (pcnt[cell_addr[2:0]] + 1 >= need[cell_addr[2:0]])
                  mem[cell_addr[2:0]] <= mem[cell_addr[2:0]] & cell_wdata;
               if (cell_addr != last_a && cell_addr != last_a + 1'b1) order_bad <= order_bad + 1;
               last_a <= cell_addr;
            end else if (cell_hv && !cell_rw && cell_regsel && cell_addr == PA) begin
               prot_cnt <= prot_cnt + 1;
            end else begin
               order_bad <= order_bad + 1;
            end
         end
      end
   end

   int checks = 0, errors = 0;
   int cyc = 0;
   bit wd_hit = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic setup(input int kind);
      for (int i = 0; i < N; i++) begin
         img_tab[i]  = 8'((i * 37 + 5 + kind * 11) & 8'hFF);
         pre_tab[i]  = 8'hFF;
         leak_tab[i] = 8'h00;
         need[i]     = 1;
      end
   endtask

   task automatic run(input bit lock, output bit got_pass, output bit got_fail);
      int lim;
      @(negedge clk); clr_req = 1'b1;
      @(negedge clk); clr_req = 1'b0;
      prot_req = lock; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R10 busy after start", busy, 1);
      lim = 0;
      while (!pass && !fail && lim < 2000) begin @(negedge clk); lim++; end
      if (lim >= 2000) chk(1'b0, "R10 run completes", lim, 0);
      got_pass = pass; got_fail = fail;
      chk(busy == 1'b0, "R10 busy drops with outcome", busy, 0);
      chk(!(pass && fail), "R10 outcome exclusive", pass + fail, 1);
      chk(wbad == 0, "R3 pulse width", wbad, 0);
      chk(order_bad == 0, "R4 address order", order_bad, 0);
   endtask

   initial begin
      while (cyc < 100000) begin @(posedge clk); cyc++; end
      wd_hit = 1'b1;
      chk(1'b0, "watchdog", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit p, f;
      int exp_p;
      bit same;
      setup(0);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !pass && !fail, "R1 status idle", {busy, pass, fail}, 0);
      chk(!cell_hv && cell_rw && !cell_regsel && !cell_wpulse, "R1 R2 read mode",
          {cell_hv, cell_rw, cell_regsel, cell_wpulse}, 4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !pass && !fail, "R1 idle after release", {busy, pass, fail}, 0);

      // sweep of pulses needed per address, all within the cap
      for (int k = 0; k < MT; k++) begin
         setup(k);
         exp_p = 0;
         for (int i = 0; i < N; i++) begin need[i] = ((i + k) % MT) + 1; exp_p += need[i]; end
         run(1'b0, p, f);
         chk(p && !f, "R4 R6 pass with retries", p, 1);
         chk(pulses == exp_p, "R6 total pulses", pulses, exp_p);
         same = 1'b1;
         for (int i = 0; i < N; i++) if (pcnt[i] != need[i] || mem[i] != img_tab[i]) same = 1'b0;
         chk(same, "R6 per-byte pulses and contents", same, 1);
         chk(last_a == AW'(N - 1), "R4 last address", last_a, N - 1);
         chk(prot_cnt == 0, "R9 no lock without request", prot_cnt, 0);
         repeat (5) @(negedge clk);
         chk(pass && !fail, "R10 pass latched", pass, 1);
      end

      // retry cap exceeded at each address
      for (int a = 0; a < N; a += 3) begin
         setup(a);
         need[a] = MT + 1;
         run(1'b0, p, f);
         chk(f && !p, "R5 fail at cap", f, 1);
         chk(pulses == a + MT, "R5 pulses before fail", pulses, a + MT);
         chk(pcnt[a] == MT, "R5 pulses on failing byte", pcnt[a], MT);
      end

      // exactly at cap still passes
      setup(7);
      need[N-1] = MT;
      run(1'b0, p, f);
      chk(p, "R5 pass at exactly cap", p, 1);

      // preloaded zero bit under a target one
      for (int a = 1; a < N; a += 3) begin
         setup(a);
         pre_tab[a] = 8'h00;
         img_tab[a] = img_tab[a] | 8'h01;
         run(1'b0, p, f);
         chk(f, "R7 unrecoverable fail", f, 1);
         chk(pulses == a && pcnt[a] == 0, "R7 no pulse on bad byte", pulses, a);
      end

      // marginal cell seen only at normal supply
      setup(2);
      leak_tab[6] = 8'h10;
      run(1'b1, p, f);
      chk(f && !p, "R8 final compare mismatch", f, 1);
      chk(pulses == N, "R8 all bytes programmed first", pulses, N);
      chk(prot_cnt == 0, "R9 no lock after failed compare", prot_cnt, 0);

      // lock requested on a clean run
      setup(4);
      run(1'b1, p, f);
      chk(p, "R9 pass with lock", p, 1);
      chk(prot_cnt == 1, "R9 one lock pulse", prot_cnt, 1);

      // start while busy is ignored
      setup(5);
      @(negedge clk); clr_req = 1'b1;
      @(negedge clk); clr_req = 1'b0;
      start = 1'b1; prot_req = 1'b0;
      @(negedge clk); start = 1'b0;
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!pass && !fail && !wd_hit) @(negedge clk);
      chk(pass && pulses == N, "R10 start while busy ignored", pulses, N);
      chk(order_bad == 0, "R10 R4 no restart", order_bad, 0);
      repeat (4) @(negedge clk);
      chk(!busy && pass, "R10 idle holds pass", pass, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule